// File: doc/BRIEF.md
# Combo Video PHY Power Sequencer

This block sequences the power, reset and enable controls of a combined MIPI/LVDS video PHY in hardware. A single start request brings the PHY up in the selected link mode. A single stop request tears it down. Each control bit is a separate output that feeds the analog macro directly. Apart from the two timed waits, every step takes exactly one clock cycle. The reset pulses and the LVDS settle time are counted in clock cycles set by parameters, so a fast bench can shrink them.

There are two bring-up paths. The MIPI path uses the divider values that arrive on its inputs and produces two short reset pulses: an analog pulse that is active-high, then a digital pulse that is active-low. The LVDS path loads a fixed divider pair, waits for the PLL to settle, and pulses the LVDS logic reset before it enables the driver. The teardown path is the same whichever mode was running. While a sequence runs, `busy_o` is high. A one-cycle `done_o` marks the last action.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset the outputs hold these values: bandgap, LDO, PLL, LVDS PLL and LVDS bandgap power-downs at 1; power-work at 00; analog reset at 0; digital and LVDS resets (both active-low) at 1; mode, dividers, lane enables, LVDS enable and clock direction at 0; busy, done and error at 0.
- R2: The clock edge that accepts a start request is edge 1. At edge 2 the bandgap power-down clears. At edge 3 power-work becomes 01.
- R3: MIPI path. Edge 4 sets mode to 001. Edge 5 loads prediv/fbdiv from the divider inputs. Edge 6 clears the LDO and PLL power-downs. Edge 9+2·RST_CYC sets all five lane enables (bit 4 is the clock lane, bits 3:0 are data lanes 3..0).
- R4: MIPI path. The analog reset rises at edge 7 and stays high for exactly RST_CYC cycles. The digital reset falls at the next edge and stays low for exactly RST_CYC cycles.
- R5: LVDS path. Edge 4 reverses the sample-clock direction. Edge 5 sets mode to 010. Edge 6 loads prediv 2 and fbdiv 28, whatever the divider inputs hold. Edge 7 powers on the LVDS PLL and bandgap.
- R6: LVDS path. The LVDS reset falls exactly SETTLE_CYC cycles after edge 7 and stays low for RST_CYC cycles. At the next edge the LVDS enable is set. At the edge after that all five LVDS lane enables are set.
- R7: Stop path, starting after the accepting edge 1. Edge 2 clears the lane enables. Edge 3 sets the LDO and PLL power-downs. Edge 4 sets power-work to 10. Edge 5 sets the bandgap power-down. Edge 6 clears the LVDS lane enables. Edge 7 clears the LVDS enable. Edge 8 powers off the LVDS PLL and bandgap.
- R8: The mode field is one-hot: bit 0 is MIPI, bit 1 is LVDS, bit 2 is TTL. A start request whose mode is anything other than 001 or 010 sets err_o, changes no output and leaves the block idle. The next request that is accepted clears err_o.
- R9: busy_o is high from the accepting edge until the edge of the last action. At that last edge done_o pulses high for one cycle. MIPI busy time is 8+2·RST_CYC cycles, LVDS busy time is 8+SETTLE_CYC+RST_CYC cycles, and stop busy time is 7 cycles.
- R10: Start and stop requests that arrive while busy are ignored. When start and stop arrive together in idle, start wins. No control output changes while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Bring-up request |
| stop_i | input | 1 | Teardown request |
| mode_i | input | 3 | One-hot link mode for start |
| prediv_i | input | PREDIV_W | MIPI pre-divider |
| fbdiv_i | input | FBDIV_W | MIPI feedback divider |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Last action pulse |
| err_o | output | 1 | Rejected start |
| bg_pd_o | output | 1 | Bandgap power-down |
| pwr_work_o | output | 2 | Power-work field |
| ldo_pd_o | output | 1 | LDO power-down |
| pll_pd_o | output | 1 | PLL power-down |
| ana_rst_o | output | 1 | Analog sync reset, active high |
| dig_rst_no | output | 1 | Digital reset, active low |
| lane_en_o | output | DATA_LANES+1 | MIPI lane enables |
| mode_sel_o | output | 3 | Mode field |
| prediv_o | output | PREDIV_W | Loaded pre-divider |
| fbdiv_o | output | FBDIV_W | Loaded feedback divider |
| clk_dir_rev_o | output | 1 | Sample-clock direction reversed |
| lvds_pll_pd_o | output | 1 | LVDS PLL power-down |
| lvds_bg_pd_o | output | 1 | LVDS bandgap power-down |
| lvds_rst_no | output | 1 | LVDS logic reset, active low |
| lvds_en_o | output | 1 | LVDS logic enable |
| lvds_lane_en_o | output | DATA_LANES+1 | LVDS lane enables |

## Verification
The bound checker runs on every cycle and tests relations that must hold at all times. The analog and digital resets are never asserted together. Lanes come on only once the PLL, and in LVDS mode the LVDS logic, is powered and out of reset. done_o lasts one cycle and occurs only outside busy. err_o never overlaps busy. The mode field stays one-hot, and no control moves while the block is idle. Three things only the directed scenarios can show: the exact edge of each step, the measured widths of the reset pulses and of the settle wait, and the fact that requests arriving mid-sequence leave the final state unchanged.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_BG_ON, ST_PWR_ON,
    ST_M_MODE, ST_M_PLL, ST_M_LDO, ST_M_ARST, ST_M_ARST_W, ST_M_DRST, ST_M_DRST_W, ST_M_LANE,
    ST_L_DIR, ST_L_MODE, ST_L_PLL, ST_L_PWR, ST_L_SETTLE_W, ST_L_RST_W, ST_L_EN, ST_L_LANE,
    ST_D_LANE, ST_D_PD, ST_D_PWR, ST_D_BG, ST_D_LLANE, ST_D_LEN, ST_D_LPD
  } step_e;

  localparam logic [2:0] MODE_MIPI = 3'b001;
  localparam logic [2:0] MODE_LVDS = 3'b010;
  localparam logic [2:0] MODE_TTL  = 3'b100;

  localparam logic [1:0] PWR_WORK_EN  = 2'b01;
  localparam logic [1:0] PWR_WORK_DIS = 2'b10;

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
  import phy_pwr_seq_pkg::*;
#(
  parameter int RST_CYC    = 200,
  parameter int SETTLE_CYC = 4000000,
  parameter int CNT_W      = 22
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [2:0]       mode_i,
  input  logic             tmr_zero_i,
  output step_e            step_o,
  output logic             act_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  step_e step_q, step_d;
  logic  lvds_q, done_q, err_q;
  logic  mode_ok, is_wait, accept;

  assign mode_ok = (mode_i == MODE_MIPI) || (mode_i == MODE_LVDS);
  assign is_wait = (step_q == ST_M_ARST_W) || (step_q == ST_M_DRST_W) ||
                   (step_q == ST_L_SETTLE_W) || (step_q == ST_L_RST_W);
  assign act_o   = (step_q != ST_IDLE) && (!is_wait || tmr_zero_i);
  assign accept  = (step_q == ST_IDLE) && ((start_i && mode_ok) || (!start_i && stop_i));

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      ST_IDLE:       if (start_i) begin
                       if (mode_ok) step_d = ST_BG_ON;
                     end else if (stop_i) step_d = ST_D_LANE;
      ST_BG_ON:      step_d = ST_PWR_ON;
      ST_PWR_ON:     step_d = lvds_q ? ST_L_DIR : ST_M_MODE;
      ST_M_MODE:     step_d = ST_M_PLL;
      ST_M_PLL:      step_d = ST_M_LDO;
      ST_M_LDO:      step_d = ST_M_ARST;
      ST_M_ARST:     step_d = ST_M_ARST_W;
      ST_M_ARST_W:   if (tmr_zero_i) step_d = ST_M_DRST;
      ST_M_DRST:     step_d = ST_M_DRST_W;
      ST_M_DRST_W:   if (tmr_zero_i) step_d = ST_M_LANE;
      ST_L_DIR:      step_d = ST_L_MODE;
      ST_L_MODE:     step_d = ST_L_PLL;
      ST_L_PLL:      step_d = ST_L_PWR;
      ST_L_PWR:      step_d = ST_L_SETTLE_W;
      ST_L_SETTLE_W: if (tmr_zero_i) step_d = ST_L_RST_W;
      ST_L_RST_W:    if (tmr_zero_i) step_d = ST_L_EN;
      ST_L_EN:       step_d = ST_L_LANE;
      ST_D_LANE:     step_d = ST_D_PD;
      ST_D_PD:       step_d = ST_D_PWR;
      ST_D_PWR:      step_d = ST_D_BG;
      ST_D_BG:       step_d = ST_D_LLANE;
      ST_D_LLANE:    step_d = ST_D_LEN;
      ST_D_LEN:      step_d = ST_D_LPD;
      default:       step_d = ST_IDLE;  // last steps of each path
    endcase
  end

  // timer is armed on the edge that enters each wait step
  assign tmr_load_o = act_o && ((step_q == ST_M_ARST) || (step_q == ST_M_DRST) ||
                                (step_q == ST_L_PWR) || (step_q == ST_L_SETTLE_W));
  assign tmr_val_o  = (step_q == ST_L_PWR) ? CNT_W'(SETTLE_CYC - 1) : CNT_W'(RST_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      lvds_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= act_o && ((step_q == ST_M_LANE) || (step_q == ST_L_LANE) || (step_q == ST_D_LPD));
      if (accept) begin
        lvds_q <= (mode_i == MODE_LVDS);
        err_q  <= 1'b0;
      end else if (step_q == ST_IDLE && start_i) begin
        err_q  <= 1'b1;
      end
    end
  end

  assign step_o = step_q;
  assign busy_o = (step_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/phy_seq_ctl.sv
module phy_seq_ctl
  import phy_pwr_seq_pkg::*;
#(
  parameter int PREDIV_W    = 5,
  parameter int FBDIV_W     = 9,
  parameter int LANE_W      = 5,
  parameter int LVDS_PREDIV = 2,
  parameter int LVDS_FBDIV  = 28
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                act_i,
  input  step_e               step_i,
  input  logic [PREDIV_W-1:0] prediv_i,
  input  logic [FBDIV_W-1:0]  fbdiv_i,
  output logic                bg_pd_o,
  output logic [1:0]          pwr_work_o,
  output logic                ldo_pd_o,
  output logic                pll_pd_o,
  output logic                ana_rst_o,
  output logic                dig_rst_no,
  output logic [LANE_W-1:0]   lane_en_o,
  output logic [2:0]          mode_sel_o,
  output logic [PREDIV_W-1:0] prediv_o,
  output logic [FBDIV_W-1:0]  fbdiv_o,
  output logic                clk_dir_rev_o,
  output logic                lvds_pll_pd_o,
  output logic                lvds_bg_pd_o,
  output logic                lvds_rst_no,
  output logic                lvds_en_o,
  output logic [LANE_W-1:0]   lvds_lane_en_o
);
  // each step's action lands on the edge that leaves the step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bg_pd_o        <= 1'b1;
      pwr_work_o     <= 2'b00;
      ldo_pd_o       <= 1'b1;
      pll_pd_o       <= 1'b1;
      ana_rst_o      <= 1'b0;
      dig_rst_no     <= 1'b1;
      lane_en_o      <= '0;
      mode_sel_o     <= 3'b000;
      prediv_o       <= '0;
      fbdiv_o        <= '0;
      clk_dir_rev_o  <= 1'b0;
      lvds_pll_pd_o  <= 1'b1;
      lvds_bg_pd_o   <= 1'b1;
      lvds_rst_no    <= 1'b1;
      lvds_en_o      <= 1'b0;
      lvds_lane_en_o <= '0;
    end else if (act_i) begin
      unique case (step_i)
        ST_BG_ON:      bg_pd_o <= 1'b0;
        ST_PWR_ON:     pwr_work_o <= PWR_WORK_EN;
        ST_M_MODE:     mode_sel_o <= MODE_MIPI;
        ST_M_PLL:      begin prediv_o <= prediv_i; fbdiv_o <= fbdiv_i; end
        ST_M_LDO:      begin ldo_pd_o <= 1'b0; pll_pd_o <= 1'b0; end
        ST_M_ARST:     ana_rst_o <= 1'b1;
        ST_M_ARST_W:   ana_rst_o <= 1'b0;
        ST_M_DRST:     dig_rst_no <= 1'b0;
        ST_M_DRST_W:   dig_rst_no <= 1'b1;
        ST_M_LANE:     lane_en_o <= '1;
        ST_L_DIR:      clk_dir_rev_o <= 1'b1;
        ST_L_MODE:     mode_sel_o <= MODE_LVDS;
        ST_L_PLL:      begin
                         prediv_o <= PREDIV_W'(LVDS_PREDIV);
                         fbdiv_o  <= FBDIV_W'(LVDS_FBDIV);
                       end
        ST_L_PWR:      begin lvds_pll_pd_o <= 1'b0; lvds_bg_pd_o <= 1'b0; end
        ST_L_SETTLE_W: lvds_rst_no <= 1'b0;
        ST_L_RST_W:    lvds_rst_no <= 1'b1;
        ST_L_EN:       lvds_en_o <= 1'b1;
        ST_L_LANE:     lvds_lane_en_o <= '1;
        ST_D_LANE:     lane_en_o <= '0;
        ST_D_PD:       begin ldo_pd_o <= 1'b1; pll_pd_o <= 1'b1; end
        ST_D_PWR:      pwr_work_o <= PWR_WORK_DIS;
        ST_D_BG:       bg_pd_o <= 1'b1;
        ST_D_LLANE:    lvds_lane_en_o <= '0;
        ST_D_LEN:      lvds_en_o <= 1'b0;
        ST_D_LPD:      begin lvds_pll_pd_o <= 1'b1; lvds_bg_pd_o <= 1'b1; end
        default:       ;
      endcase
    end
  end
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_pwr_seq_pkg::*;
#(
  parameter int RST_CYC     = 200,
  parameter int SETTLE_CYC  = 4000000,
  parameter int PREDIV_W    = 5,
  parameter int FBDIV_W     = 9,
  parameter int DATA_LANES  = 4,
  parameter int LVDS_PREDIV = 2,
  parameter int LVDS_FBDIV  = 28
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic [2:0]            mode_i,
  input  logic [PREDIV_W-1:0]   prediv_i,
  input  logic [FBDIV_W-1:0]    fbdiv_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic                  bg_pd_o,
  output logic [1:0]            pwr_work_o,
  output logic                  ldo_pd_o,
  output logic                  pll_pd_o,
  output logic                  ana_rst_o,
  output logic                  dig_rst_no,
  output logic [DATA_LANES:0]   lane_en_o,
  output logic [2:0]            mode_sel_o,
  output logic [PREDIV_W-1:0]   prediv_o,
  output logic [FBDIV_W-1:0]    fbdiv_o,
  output logic                  clk_dir_rev_o,
  output logic                  lvds_pll_pd_o,
  output logic                  lvds_bg_pd_o,
  output logic                  lvds_rst_no,
  output logic                  lvds_en_o,
  output logic [DATA_LANES:0]   lvds_lane_en_o
);
  localparam int LANE_W  = DATA_LANES + 1;
  localparam int MAX_CYC = (SETTLE_CYC > RST_CYC) ? SETTLE_CYC : RST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  step_e            step;
  logic             act, tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  phy_seq_fsm #(
    .RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .stop_i, .mode_i,
    .tmr_zero_i(tmr_zero), .step_o(step), .act_o(act),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .busy_o, .done_o, .err_o
  );

  phy_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  phy_seq_ctl #(
    .PREDIV_W(PREDIV_W), .FBDIV_W(FBDIV_W), .LANE_W(LANE_W),
    .LVDS_PREDIV(LVDS_PREDIV), .LVDS_FBDIV(LVDS_FBDIV)
  ) u_ctl (
    .clk_i, .rst_ni, .act_i(act), .step_i(step), .prediv_i, .fbdiv_i,
    .bg_pd_o, .pwr_work_o, .ldo_pd_o, .pll_pd_o, .ana_rst_o, .dig_rst_no,
    .lane_en_o, .mode_sel_o, .prediv_o, .fbdiv_o, .clk_dir_rev_o,
    .lvds_pll_pd_o, .lvds_bg_pd_o, .lvds_rst_no, .lvds_en_o, .lvds_lane_en_o
  );
endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk #(
  parameter int LANE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              bg_pd_o,
  input logic [1:0]        pwr_work_o,
  input logic              ldo_pd_o,
  input logic              pll_pd_o,
  input logic              ana_rst_o,
  input logic              dig_rst_no,
  input logic [LANE_W-1:0] lane_en_o,
  input logic [2:0]        mode_sel_o,
  input logic              lvds_rst_no,
  input logic              lvds_en_o,
  input logic              lvds_pll_pd_o,
  input logic [LANE_W-1:0] lvds_lane_en_o
);
  assert_rst_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ana_rst_o && !dig_rst_no));

  assert_lane_after_pll_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lane_en_o != '0) |-> (!pll_pd_o && !ldo_pd_o && dig_rst_no && !ana_rst_o));

  assert_lvds_lane_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lvds_lane_en_o != '0) |-> (lvds_en_o && lvds_rst_no && !lvds_pll_pd_o));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o ##1 !done_o));

  assert_err_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);

  assert_mode_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mode_sel_o));

  assert_quiet_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |->
      $stable({bg_pd_o, pwr_work_o, ldo_pd_o, pll_pd_o, lane_en_o, mode_sel_o,
               lvds_en_o, lvds_lane_en_o, lvds_pll_pd_o}));
endmodule

bind phy_pwr_seq phy_pwr_seq_chk #(.LANE_W(DATA_LANES + 1)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .bg_pd_o(bg_pd_o), .pwr_work_o(pwr_work_o), .ldo_pd_o(ldo_pd_o), .pll_pd_o(pll_pd_o),
  .ana_rst_o(ana_rst_o), .dig_rst_no(dig_rst_no), .lane_en_o(lane_en_o),
  .mode_sel_o(mode_sel_o), .lvds_rst_no(lvds_rst_no), .lvds_en_o(lvds_en_o),
  .lvds_pll_pd_o(lvds_pll_pd_o), .lvds_lane_en_o(lvds_lane_en_o)
);

// File: tb/tb_phy_pwr_seq.sv
module tb_phy_pwr_seq;
  localparam int RST = 4;
  localparam int SET = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0;
  logic [2:0] mode_i = 3'b000;
  logic [4:0] prediv_i = '0;
  logic [8:0] fbdiv_i = '0;
  logic       busy_o, done_o, err_o, bg_pd_o, ldo_pd_o, pll_pd_o, ana_rst_o, dig_rst_no;
  logic [1:0] pwr_work_o;
  logic [4:0] lane_en_o, lvds_lane_en_o, prediv_o;
  logic [2:0] mode_sel_o;
  logic [8:0] fbdiv_o;
  logic       clk_dir_rev_o, lvds_pll_pd_o, lvds_bg_pd_o, lvds_rst_no, lvds_en_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  phy_pwr_seq #(.RST_CYC(RST), .SETTLE_CYC(SET)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // drive a request; returns sampled just after the accepting edge (cycle 1)
  task automatic kick(input logic st, input logic sp, input logic [2:0] m);
    @(posedge clk_i); #1;
    start_i = st; stop_i = sp; mode_i = m;
    @(posedge clk_i); #1;
    start_i = 1'b0; stop_i = 1'b0;
  endtask

  task automatic t_reset();
    chk_eq("R1", "bg_pd", bg_pd_o, 1);
    chk_eq("R1", "pwr_work", pwr_work_o, 0);
    chk_eq("R1", "ldo/pll pd", {ldo_pd_o, pll_pd_o}, 3);
    chk_eq("R1", "resets", {ana_rst_o, dig_rst_no, lvds_rst_no}, 3);
    chk_eq("R1", "lanes", {lane_en_o, lvds_lane_en_o}, 0);
    chk_eq("R1", "mode/div", {mode_sel_o, prediv_o, fbdiv_o}, 0);
    chk_eq("R1", "lvds pd", {lvds_pll_pd_o, lvds_bg_pd_o}, 3);
    chk_eq("R1", "status", {busy_o, done_o, err_o, lvds_en_o, clk_dir_rev_o}, 0);
  endtask

  task automatic t_bad_mode(input logic [2:0] m);
    kick(1'b1, 1'b0, m);
    chk_eq("R8", "err after bad mode", err_o, 1);
    chk_eq("R8", "busy after bad mode", busy_o, 0);
    repeat (3) @(posedge clk_i);
    #1;
    chk_eq("R8", "bg_pd untouched", bg_pd_o, 1);
    chk_eq("R8", "mode untouched", mode_sel_o, 0);
  endtask

  task automatic t_mipi(input logic [4:0] pd, input logic [8:0] fd, input bit interfere, input bit with_stop);
    int t_bg = -1, t_pw = -1, t_md = -1, t_pl = -1, t_ldo = -1, t_ar = -1, t_arf = -1;
    int t_dr = -1, t_drr = -1, t_ln = -1, t_dn = -1, nbusy = 0, ndone = 0;
    prediv_i = pd; fbdiv_i = fd;
    kick(1'b1, with_stop, 3'b001);
    chk_eq("R8", "err cleared by accept", err_o, 0);
    for (int cyc = 1; cyc <= 12 + 2 * RST; cyc++) begin
      if (cyc > 1) begin @(posedge clk_i); #1; end
      if (interfere && cyc == 3) begin start_i = 1'b1; stop_i = 1'b1; mode_i = 3'b010; end
      if (interfere && cyc == 4) begin start_i = 1'b0; stop_i = 1'b0; end
      if (busy_o) nbusy++;
      if (done_o) begin ndone++; if (t_dn < 0) t_dn = cyc; end
      if (t_bg < 0 && !bg_pd_o) t_bg = cyc;
      if (t_pw < 0 && pwr_work_o == 2'b01) t_pw = cyc;
      if (t_md < 0 && mode_sel_o == 3'b001) t_md = cyc;
      if (t_pl < 0 && prediv_o == pd && fbdiv_o == fd) t_pl = cyc;
      if (t_ldo < 0 && !ldo_pd_o && !pll_pd_o) t_ldo = cyc;
      if (t_ar < 0 && ana_rst_o) t_ar = cyc;
      if (t_ar >= 0 && t_arf < 0 && !ana_rst_o) t_arf = cyc;
      if (t_dr < 0 && !dig_rst_no) t_dr = cyc;
      if (t_dr >= 0 && t_drr < 0 && dig_rst_no) t_drr = cyc;
      if (t_ln < 0 && lane_en_o == 5'h1f) t_ln = cyc;
    end
    chk_eq("R2", "mipi bg clear edge", t_bg, 2);
    chk_eq("R2", "mipi pwr_work edge", t_pw, 3);
    chk_eq("R3", "mipi mode edge", t_md, 4);
    chk_eq("R3", "mipi divider edge", t_pl, 5);
    chk_eq("R3", "mipi ldo/pll on edge", t_ldo, 6);
    chk_eq("R4", "analog reset rise", t_ar, 7);
    chk_eq("R4", "analog reset width", t_arf - t_ar, RST);
    chk_eq("R4", "digital reset fall", t_dr, 8 + RST);
    chk_eq("R4", "digital reset width", t_drr - t_dr, RST);
    chk_eq("R3", "mipi lanes edge", t_ln, 9 + 2 * RST);
    chk_eq("R9", "mipi done edge", t_dn, 9 + 2 * RST);
    chk_eq("R9", "mipi done count", ndone, 1);
    chk_eq("R9", "mipi busy cycles", nbusy, 8 + 2 * RST);
    if (interfere) chk_eq("R10", "mode after ignored requests", mode_sel_o, 3'b001);
  endtask

  task automatic t_lvds();
    int t_bg = -1, t_pw = -1, t_dir = -1, t_md = -1, t_pl = -1, t_lp = -1, t_lr = -1;
    int t_lrr = -1, t_le = -1, t_ll = -1, t_dn = -1, nbusy = 0;
    prediv_i = 5'd7; fbdiv_i = 9'd300;
    kick(1'b1, 1'b0, 3'b010);
    for (int cyc = 1; cyc <= 12 + SET + RST; cyc++) begin
      if (cyc > 1) begin @(posedge clk_i); #1; end
      if (cyc == 10) begin start_i = 1'b1; mode_i = 3'b001; end
      if (cyc == 11) start_i = 1'b0;
      if (busy_o) nbusy++;
      if (t_dn < 0 && done_o) t_dn = cyc;
      if (t_bg < 0 && !bg_pd_o) t_bg = cyc;
      if (t_pw < 0 && pwr_work_o == 2'b01) t_pw = cyc;
      if (t_dir < 0 && clk_dir_rev_o) t_dir = cyc;
      if (t_md < 0 && mode_sel_o == 3'b010) t_md = cyc;
      if (t_pl < 0 && prediv_o == 5'd2 && fbdiv_o == 9'd28) t_pl = cyc;
      if (t_lp < 0 && !lvds_pll_pd_o && !lvds_bg_pd_o) t_lp = cyc;
      if (t_lr < 0 && !lvds_rst_no) t_lr = cyc;
      if (t_lr >= 0 && t_lrr < 0 && lvds_rst_no) t_lrr = cyc;
      if (t_le < 0 && lvds_en_o) t_le = cyc;
      if (t_ll < 0 && lvds_lane_en_o == 5'h1f) t_ll = cyc;
    end
    chk_eq("R2", "lvds bg clear edge", t_bg, 2);
    chk_eq("R2", "lvds pwr_work edge", t_pw, 3);
    chk_eq("R5", "clock direction edge", t_dir, 4);
    chk_eq("R5", "lvds mode edge", t_md, 5);
    chk_eq("R5", "fixed divider edge", t_pl, 6);
    chk_eq("R5", "lvds pll/bg on edge", t_lp, 7);
    chk_eq("R6", "lvds reset fall", t_lr, 7 + SET);
    chk_eq("R6", "lvds reset width", t_lrr - t_lr, RST);
    chk_eq("R6", "lvds enable edge", t_le, 8 + SET + RST);
    chk_eq("R6", "lvds lanes edge", t_ll, 9 + SET + RST);
    chk_eq("R9", "lvds done edge", t_dn, 9 + SET + RST);
    chk_eq("R9", "lvds busy cycles", nbusy, 8 + SET + RST);
    chk_eq("R10", "mode kept during busy start", mode_sel_o, 3'b010);
    chk_eq("R10", "mipi lanes untouched", lane_en_o, 0);
  endtask

  task automatic t_stop(input bit after_lvds);
    int t_ln = -1, t_pd = -1, t_pw = -1, t_bg = -1, t_ll = -1, t_le = -1, t_lp = -1;
    int t_dn = -1, nbusy = 0;
    kick(1'b0, 1'b1, 3'b000);
    for (int cyc = 1; cyc <= 11; cyc++) begin
      if (cyc > 1) begin @(posedge clk_i); #1; end
      if (busy_o) nbusy++;
      if (t_dn < 0 && done_o) t_dn = cyc;
      if (t_ln < 0 && lane_en_o == 0) t_ln = cyc;
      if (t_pd < 0 && ldo_pd_o && pll_pd_o) t_pd = cyc;
      if (t_pw < 0 && pwr_work_o == 2'b10) t_pw = cyc;
      if (t_bg < 0 && bg_pd_o) t_bg = cyc;
      if (t_ll < 0 && lvds_lane_en_o == 0) t_ll = cyc;
      if (t_le < 0 && !lvds_en_o) t_le = cyc;
      if (t_lp < 0 && lvds_pll_pd_o && lvds_bg_pd_o) t_lp = cyc;
    end
    if (!after_lvds) begin
      chk_eq("R7", "lanes off edge", t_ln, 2);
      chk_eq("R7", "ldo/pll pd edge", t_pd, 3);
    end else begin
      chk_eq("R7", "lvds lanes off edge", t_ll, 6);
      chk_eq("R7", "lvds enable off edge", t_le, 7);
      chk_eq("R7", "lvds pll/bg off edge", t_lp, 8);
    end
    chk_eq("R7", "pwr_work disable edge", t_pw, 4);
    chk_eq("R7", "bg pd edge", t_bg, 5);
    chk_eq("R9", "stop done edge", t_dn, 8);
    chk_eq("R9", "stop busy cycles", nbusy, 7);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    t_reset();
    t_bad_mode(3'b100);
    t_bad_mode(3'b011);
    t_mipi(5'd3, 9'd100, 1'b0, 1'b0);
    t_stop(1'b0);
    t_lvds();
    t_stop(1'b1);
    t_mipi(5'd9, 9'd411, 1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule